// File: doc/BRIEF.md
# Debug-to-CPU Mailbox

This block is a two-way, one-word mailbox between an external debug port and the local CPU. Each side has its own register port with address, write enable, write data, read enable and read data. Four word registers are visible from both ports. The forward channel carries a word from the debug tool to the CPU. The return channel carries a word from the CPU back to the tool.

Each channel has a "full" status bit. The producing side sets it by writing the data word, and the consuming side clears it by reading that word. Each channel also has a group of spare flag bits whose meaning is left to software. Two single-cycle event outputs let an interrupt controller react in two situations: when a word arrives for the CPU, and when the tool has consumed the word the CPU left for it.

Read data is combinational: it is valid in the same cycle as the read enable. Clear-on-read side effects take place at the closing clock edge. The debug wire protocol and any clock-domain crossing are handled outside this block.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, every register reads 0 from both ports and both event outputs are low.
- R2: Register map on both ports: address 0 is the forward data word, address 1 is forward control ({flags[31:1], full[0]}), address 2 is the return data word, and address 3 is return control ({24'b0, flags[7:1], full[0]}). A debug write to address 0 stores the word and sets forward full. The CPU reads the word at address 0.
- R3: A CPU read of address 0 clears forward full. A debug read of address 0 leaves it unchanged.
- R4: A debug write to address 1 loads forward flags from write data bits 31:1, and bit 0 is ignored. CPU writes to addresses 0 and 1 have no effect.
- R5: A CPU write to address 2 stores the word and sets return full. A debug read of address 2 clears it. A CPU read of address 2 leaves it unchanged.
- R6: A CPU write to address 3 loads return flags from write data bits 7:1. Control bit 0 and bits 31:8 are not writable, and bits 31:8 read 0. Debug writes to addresses 2 and 3 have no effect.
- R7: When a set and a clear of the same full bit fall in one cycle, the bit ends up set and the new word is stored.
- R8: Writing a data word while its full bit is already set replaces the word and keeps the bit set.
- R9: `tx_arrive_evt` is high for exactly the one cycle after the edge at which forward full goes from 0 to 1. A write that overwrites a word while the bit is already set raises no event.
- R10: `rx_taken_evt` is high for exactly the one cycle after the edge at which return full goes from 1 to 0.
- R11: Read data on a port is 0 whenever that port's read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_addr | input | 2 | Debug-side word address |
| dbg_we | input | 1 | Debug-side write enable |
| dbg_wdata | input | 32 | Debug-side write data |
| dbg_re | input | 1 | Debug-side read enable |
| dbg_rdata | output | 32 | Debug-side read data |
| cpu_addr | input | 2 | CPU-side word address |
| cpu_we | input | 1 | CPU-side write enable |
| cpu_wdata | input | 32 | CPU-side write data |
| cpu_re | input | 1 | CPU-side read enable |
| cpu_rdata | output | 32 | CPU-side read data |
| tx_arrive_evt | output | 1 | Pulse: a word has arrived for the CPU |
| rx_taken_evt | output | 1 | Pulse: the debug side has consumed the CPU's word |

## Verification
The case hardest to reach is a collision: one port sets a full bit in the same clock that the other port clears it. Ordinary traffic never lines the two up. To create it, the stimulus drives both ports in a single cycle, using one access task that handles both sides at once. That task covers the write-meets-read collision in each direction. It also covers an overwrite while the bit is already set, where the event must stay low. The spare flag fields are swept over every value (return) and every single bit (forward).

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_TX_DATA = 2'd0,
    REG_TX_CTRL = 2'd1,
    REG_RX_DATA = 2'd2,
    REG_RX_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dbgmb_chan.sv
// One mailbox direction: data word, full bit, spare flags, event pulse.
module dbgmb_chan #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned FLAG_W     = 7,
  parameter bit          EVT_ON_SET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_in,
  input  logic              data_rd,
  input  logic              flag_we,
  input  logic [FLAG_W-1:0] flag_in,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic [FLAG_W-1:0] flag_q,
  output logic              evt_o
);
  logic full_d;
  logic evt_d;
  logic evt_q;

  // Set has precedence over the consuming read.
  always_comb begin
    full_d = full_q;
    if (data_we)      full_d = 1'b1;
    else if (data_rd) full_d = 1'b0;
  end

  generate
    if (EVT_ON_SET) begin : g_evt_rise
      always_comb evt_d = full_d & ~full_q;
    end else begin : g_evt_fall
      always_comb evt_d = ~full_d & full_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= '0;
      full_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (data_we) data_q <= data_in;
      if (flag_we) flag_q <= flag_in;
      full_q <= full_d;
      evt_q  <= evt_d;
    end
  end

  assign evt_o = evt_q;

  // R7 / R8: a write always leaves the full bit set.
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> full_q);
  // R3 and R5: a consuming read without a write empties the channel.
  p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !data_we) |=> !full_q);
  // R8: the word only changes on a write.
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(data_q));
  // R4 and R6: flags only change on a flag write.
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flag_q));
  // R9 and R10: the event never lasts two cycles.
  p_evt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);
endmodule

// File: rtl/dbgmb_rdmux.sv
// Read-data selection for one port; zero when not reading.
module dbgmb_rdmux
  import dbgmb_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RX_FLAG_W = 7
) (
  input  logic                 re,
  input  logic [REG_AW-1:0]    addr,
  input  logic [DATA_W-1:0]    tx_data,
  input  logic                 tx_full,
  input  logic [DATA_W-2:0]    tx_flags,
  input  logic [DATA_W-1:0]    rx_data,
  input  logic                 rx_full,
  input  logic [RX_FLAG_W-1:0] rx_flags,
  output logic [DATA_W-1:0]    rdata
);
  localparam int unsigned PAD_W = DATA_W - RX_FLAG_W - 1;

  always_comb begin
    rdata = '0;
    if (re) begin
      case (addr)
        REG_TX_DATA: rdata = tx_data;
        REG_TX_CTRL: rdata = {tx_flags, tx_full};
        REG_RX_DATA: rdata = rx_data;
        default:     rdata = {{PAD_W{1'b0}}, rx_flags, rx_full};
      endcase
    end
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbgmb_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RX_FLAG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] dbg_addr,
  input  logic              dbg_we,
  input  logic [DATA_W-1:0] dbg_wdata,
  input  logic              dbg_re,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_re,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              tx_arrive_evt,
  output logic              rx_taken_evt
);
  localparam int unsigned TX_FLAG_W = DATA_W - 1;

  logic                 tx_data_we, tx_data_rd, tx_flag_we;
  logic                 rx_data_we, rx_data_rd, rx_flag_we;
  logic [DATA_W-1:0]    tx_data, rx_data;
  logic                 tx_full, rx_full;
  logic [TX_FLAG_W-1:0] tx_flags;
  logic [RX_FLAG_W-1:0] rx_flags;

  // Forward channel: debug produces, CPU consumes.
  assign tx_data_we = dbg_we & (dbg_addr == REG_TX_DATA);
  assign tx_flag_we = dbg_we & (dbg_addr == REG_TX_CTRL);
  assign tx_data_rd = cpu_re & (cpu_addr == REG_TX_DATA);
  // Return channel: CPU produces, debug consumes.
  assign rx_data_we = cpu_we & (cpu_addr == REG_RX_DATA);
  assign rx_flag_we = cpu_we & (cpu_addr == REG_RX_CTRL);
  assign rx_data_rd = dbg_re & (dbg_addr == REG_RX_DATA);

  dbgmb_chan #(.DATA_W(DATA_W), .FLAG_W(TX_FLAG_W), .EVT_ON_SET(1'b1)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_we (tx_data_we),
    .data_in (dbg_wdata),
    .data_rd (tx_data_rd),
    .flag_we (tx_flag_we),
    .flag_in (dbg_wdata[DATA_W-1:1]),
    .data_q  (tx_data),
    .full_q  (tx_full),
    .flag_q  (tx_flags),
    .evt_o   (tx_arrive_evt)
  );

  dbgmb_chan #(.DATA_W(DATA_W), .FLAG_W(RX_FLAG_W), .EVT_ON_SET(1'b0)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_we (rx_data_we),
    .data_in (cpu_wdata),
    .data_rd (rx_data_rd),
    .flag_we (rx_flag_we),
    .flag_in (cpu_wdata[RX_FLAG_W:1]),
    .data_q  (rx_data),
    .full_q  (rx_full),
    .flag_q  (rx_flags),
    .evt_o   (rx_taken_evt)
  );

  dbgmb_rdmux #(.DATA_W(DATA_W), .RX_FLAG_W(RX_FLAG_W)) u_dbg_rd (
    .re       (dbg_re),
    .addr     (dbg_addr),
    .tx_data  (tx_data),
    .tx_full  (tx_full),
    .tx_flags (tx_flags),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .rx_flags (rx_flags),
    .rdata    (dbg_rdata)
  );

  dbgmb_rdmux #(.DATA_W(DATA_W), .RX_FLAG_W(RX_FLAG_W)) u_cpu_rd (
    .re       (cpu_re),
    .addr     (cpu_addr),
    .tx_data  (tx_data),
    .tx_full  (tx_full),
    .tx_flags (tx_flags),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .rx_flags (rx_flags),
    .rdata    (cpu_rdata)
  );

  // R9: an arrival event follows a debug data write.
  p_tx_evt_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_arrive_evt |-> ($past(tx_data_we) && !$past(tx_full)));
  // R10: a taken event follows a debug read of the return word.
  p_rx_evt_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_taken_evt |-> ($past(rx_data_rd) && !rx_full));
  // R3: a debug read of the forward word leaves the full bit alone.
  p_tx_dbg_read_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_data_rd) |=> tx_full);
endmodule

// File: tb/dbg_mailbox_tb.sv
module dbg_mailbox_tb_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  dbg_addr, cpu_addr;
  logic        dbg_we, dbg_re, cpu_we, cpu_re;
  logic [31:0] dbg_wdata, cpu_wdata, dbg_rdata, cpu_rdata;
  logic        tx_arrive_evt, rx_taken_evt;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // Bench-side model of the mailbox state.
  logic [31:0] m_txd, m_rxd;
  logic        m_txfull, m_rxfull;
  logic [30:0] m_txflags;
  logic [6:0]  m_rxflags;

  dbg_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .dbg_addr(dbg_addr), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .dbg_re(dbg_re), .dbg_rdata(dbg_rdata),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
    .tx_arrive_evt(tx_arrive_evt), .rx_taken_evt(rx_taken_evt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] reg_val(input logic [1:0] a);
    case (a)
      2'd0:    return m_txd;
      2'd1:    return {m_txflags, m_txfull};
      2'd2:    return m_rxd;
      default: return {24'h0, m_rxflags, m_rxfull};
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle of traffic on both ports, checked against the model.
  task automatic step(input string tag,
                      input logic dwe, input logic dre, input logic [1:0] da,
                      input logic [31:0] dwd,
                      input logic cwe, input logic cre, input logic [1:0] ca,
                      input logic [31:0] cwd);
    logic prev_tx, prev_rx, e_tx, e_rx;
    @(negedge clk);
    dbg_we = dwe; dbg_re = dre; dbg_addr = da; dbg_wdata = dwd;
    cpu_we = cwe; cpu_re = cre; cpu_addr = ca; cpu_wdata = cwd;
    #1;
    chk(tag, "dbg_rdata", dbg_rdata, dre ? reg_val(da) : 32'h0);
    chk(tag, "cpu_rdata", cpu_rdata, cre ? reg_val(ca) : 32'h0);
    prev_tx = m_txfull;
    prev_rx = m_rxfull;
    if (dwe && da == 2'd0) m_txd = dwd;
    if (dwe && da == 2'd1) m_txflags = dwd[31:1];
    if (dwe && da == 2'd0)      m_txfull = 1'b1;
    else if (cre && ca == 2'd0) m_txfull = 1'b0;
    if (cwe && ca == 2'd2) m_rxd = cwd;
    if (cwe && ca == 2'd3) m_rxflags = cwd[7:1];
    if (cwe && ca == 2'd2)      m_rxfull = 1'b1;
    else if (dre && da == 2'd2) m_rxfull = 1'b0;
    e_tx = !prev_tx && m_txfull;
    e_rx = prev_rx && !m_rxfull;
    @(negedge clk);
    dbg_we = 0; dbg_re = 0; cpu_we = 0; cpu_re = 0;
    chk(tag, "tx_arrive_evt", {31'h0, tx_arrive_evt}, {31'h0, e_tx});
    chk(tag, "rx_taken_evt", {31'h0, rx_taken_evt}, {31'h0, e_rx});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0;
    dbg_we = 0; dbg_re = 0; dbg_addr = 0; dbg_wdata = 0;
    cpu_we = 0; cpu_re = 0; cpu_addr = 0; cpu_wdata = 0;
    m_txd = 0; m_rxd = 0; m_txfull = 0; m_rxfull = 0;
    m_txflags = 0; m_rxflags = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state on every address from both ports.
    for (int a = 0; a < 4; a++)
      step("R1", 0, 1, 2'(a), 0, 0, 1, 2'(a), 0);

    // R2, R3, R9: forward channel over a sweep of words.
    for (int i = 0; i < 16; i++) begin
      logic [31:0] w;
      w = (32'h1111_1111 * i) ^ (32'h8000_0001 << (i % 4));
      step("R2", 1, 0, 2'd0, w, 0, 0, 2'd0, 0);
      step("R3", 0, 1, 2'd0, 0, 0, 1, 2'd1, 0);
      step("R3", 0, 0, 2'd0, 0, 0, 1, 2'd0, 0);
      step("R9", 0, 1, 2'd1, 0, 0, 1, 2'd1, 0);
    end

    // R8: overwrite while full, no second event.
    step("R8", 1, 0, 2'd0, 32'hAAAA_0001, 0, 0, 2'd0, 0);
    step("R8", 1, 0, 2'd0, 32'h5555_0002, 0, 1, 2'd1, 0);
    step("R8", 0, 0, 2'd0, 0, 0, 1, 2'd0, 0);
    step("R8", 1, 0, 2'd2, 0, 1, 0, 2'd2, 32'hC0DE_0003);
    step("R8", 0, 0, 2'd0, 0, 1, 0, 2'd2, 32'hC0DE_0004);
    step("R10", 0, 1, 2'd2, 0, 0, 1, 2'd3, 0);

    // R4: every forward flag bit; bit 0 of the write is ignored.
    for (int k = 0; k < 31; k++) begin
      step("R4", 1, 0, 2'd1, (32'h2 << k) | 32'h1, 0, 0, 2'd0, 0);
      step("R4", 0, 1, 2'd1, 0, 0, 1, 2'd1, 0);
    end
    // R4: CPU writes to forward registers have no effect.
    step("R4", 0, 0, 2'd0, 0, 1, 0, 2'd0, 32'hDEAD_BEEF);
    step("R4", 0, 0, 2'd0, 0, 1, 0, 2'd1, 32'hFFFF_FFFF);
    step("R4", 0, 1, 2'd0, 0, 0, 1, 2'd1, 0);

    // R5, R10: return channel over a sweep of words.
    for (int i = 0; i < 16; i++) begin
      logic [31:0] w;
      w = ~(32'h0F0F_0F0F * (i + 1)) ^ (32'h1 << (2 * i));
      step("R5", 0, 0, 2'd0, 0, 1, 0, 2'd2, w);
      step("R5", 0, 1, 2'd3, 0, 0, 1, 2'd2, 0);
      step("R10", 0, 1, 2'd2, 0, 0, 1, 2'd3, 0);
      step("R5", 0, 1, 2'd3, 0, 0, 0, 2'd0, 0);
    end

    // R6: every return flag value; upper bits and bit 0 not writable.
    for (int v = 0; v < 128; v++) begin
      step("R6", 0, 0, 2'd0, 0, 1, 0, 2'd3, 32'hFFFF_FF01 | (32'(v) << 1));
      step("R6", 0, 1, 2'd3, 0, 0, 1, 2'd3, 0);
    end
    // R6: debug writes to return registers have no effect.
    step("R6", 1, 0, 2'd3, 32'h0000_00FE, 0, 0, 2'd0, 0);
    step("R6", 1, 0, 2'd2, 32'h1234_5678, 0, 1, 2'd2, 0);
    step("R6", 0, 1, 2'd3, 0, 0, 1, 2'd3, 0);

    // R7: collisions of set and clear in one cycle, both channels.
    step("R7", 0, 0, 2'd0, 0, 0, 1, 2'd0, 0);
    step("R7", 1, 0, 2'd0, 32'hFACE_0011, 0, 1, 2'd0, 0);
    step("R7", 1, 0, 2'd0, 32'hFACE_0022, 0, 1, 2'd0, 0);
    step("R7", 0, 1, 2'd1, 0, 0, 1, 2'd0, 0);
    step("R7", 0, 1, 2'd2, 0, 1, 0, 2'd2, 32'hBEEF_0033);
    step("R7", 0, 1, 2'd2, 0, 1, 0, 2'd2, 32'hBEEF_0044);
    step("R7", 0, 1, 2'd2, 0, 0, 1, 2'd3, 0);

    // R11: idle read enables give zero read data.
    step("R11", 1, 0, 2'd0, 32'h7777_7777, 0, 0, 2'd0, 0);
    step("R11", 0, 0, 2'd1, 0, 0, 0, 2'd1, 0);
    step("R11", 0, 1, 2'd0, 0, 0, 1, 2'd0, 0);

    summary();
  end
endmodule